// File: doc/BRIEF.md
# Conversion Result Read-Out Port with Partial-Transfer Rules

This block is the device side of a serial peripheral link for a data converter. Finished conversion results enter a small first-in first-out store. The host reads them out over the serial link, most significant bit first. Each result is sent as two bytes, and the four top bits of each result are zeros. The same link also writes a few configuration registers and carries a command that resets the store.

The block's defining feature is that it handles transfers cut short by the chip select. It never waits for a full byte. Bits that the host has clocked count as consumed, and any part of a result left unread is discarded by fixed rules. A register write that stops early keeps the bits it did receive. If chip select falls while a conversion is still in progress, the block sets a sticky corruption flag.

All serial pins are sampled in the system clock domain and must run well below that clock. Every frame begins with a type bit on the data input. A 0 starts a read frame, and that first clock also consumes a result bit. A 1 starts a write frame.

Top module: `result_spi_port`

## Requirements
- R1: A result is sent as a 16-bit word `{4'b0, data[11:0]}`, most significant bit first, as two 8-bit bytes. After the 16th bit the next stored result begins at its bit 15.
- R2: While chip select is low, the serial output changes only after a falling serial-clock edge or a chip-select edge. While chip select is high, the output is 0. The data input is sampled on rising serial-clock edges.
- R3: If chip select rises after k bits (1 ≤ k ≤ 7) of a result's first byte, the next byte read returns bits 15-k down to 8-k of that result. The rest of that result is then discarded.
- R4: If the first byte is read in full and chip select rises part-way through the second byte, the rest of that result is discarded. The next result then reads out complete.
- R5: Reading while the store is empty returns 0 bits and leaves the read position unchanged. A result pushed afterwards reads out from its bit 15.
- R6: In a write frame, the type bit is 1, then 2 address bits, then 8 data bits, each most significant first. Addresses 0 to 2 load registers, exposed as `cfg_regs = {reg2, reg1, reg0}`. A write frame consumes no stored results.
- R7: A register write that stops after n data bits changes only register bits 7 down to 8-n and keeps the lower bits.
- R8: Chip select falling while `eoc_n` is high sets `corrupt`. The flag stays set until the store-reset command.
- R9: While `corrupt` is set, incoming results are dropped.
- R10: A write frame to address 3 whose first data bit is 1 empties the store, resets the read position and clears `corrupt`.
- R11: A result pushed while the store holds DEPTH entries is dropped. Stored entries are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| eoc_n | input | 1 | Low when no conversion is running |
| res_valid | input | 1 | A result is offered this cycle |
| res_data | input | DATA_W | Result value |
| cfg_regs | output | NREG*CFG_W | Configuration registers, register 0 in the low bits |
| corrupt | output | 1 | Sticky corruption flag |

## Verification
The hardest state to reach is a result whose first byte was cut at an arbitrary bit. Its second byte then begins mid-word, and the entry behind it must still arrive intact. Directed loops stop the first byte, and separately the second byte, at each of bits 1 to 7. After each stop they read the following byte and a whole later result, with the expected words computed by shifting in the bench. Random frames of 1 to 24 bits, mixed with pushes and partial register writes, then cross entry boundaries at uneven offsets.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    localparam int ENTRY_W = 16;
    localparam int BYTE_W  = 8;
    localparam int POS_W   = $clog2(ENTRY_W);
    localparam int BCNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_PEND,
        FR_READ,
        FR_WRITE
    } frame_e;
endpackage

// File: rtl/rsp_edges.sv
module rsp_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise
);
    typedef struct packed {
        logic sclk;
        logic cs_n;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.sclk = sclk;
        smp_d.cs_n = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '{sclk: 1'b0, cs_n: 1'b1};
        else        smp_q <= smp_d;
    end

    assign sclk_rise = sclk & ~smp_q.sclk & ~cs_n;
    assign sclk_fall = ~sclk & smp_q.sclk & ~cs_n;
    assign cs_fall   = ~cs_n & smp_q.cs_n;
    assign cs_rise   = cs_n & ~smp_q.cs_n;
endmodule

// File: rtl/rsp_store.sv
module rsp_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 12,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              clr,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic [CNT_W-1:0]  level
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wptr;
        logic [PTR_W-1:0]             rptr;
        logic [CNT_W-1:0]             level;
    } store_t;

    store_t st_d, st_q;
    logic   do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.level != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.level != '0);
        if (clr) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.level = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wptr] = push_data;
                st_d.wptr           = step(st_q.wptr);
            end
            if (do_pop) st_d.rptr = step(st_q.rptr);
            st_d.level = st_q.level + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rptr];
    assign empty = (st_q.level == '0);
    assign level = st_q.level;
endmodule

// File: rtl/rsp_reader.sv
module rsp_reader
    import rsp_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              consume,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_fall,
    input  logic              read_frame,
    input  logic              clr,
    input  logic [DATA_W-1:0] head,
    input  logic              empty,
    output logic              pop,
    output logic              dout
);
    typedef struct packed {
        logic              phase;
        logic [POS_W-1:0]  bidx;
        logic [BCNT_W-1:0] bcnt;
        logic              dout;
    } rd_t;

    rd_t              rd_d, rd_q;
    logic [ENTRY_W-1:0] entry;
    logic             cur_bit;

    assign entry   = ENTRY_W'(head);
    assign cur_bit = empty ? 1'b0 : entry[POS_W'(ENTRY_W - 1) - rd_q.bidx];

    always_comb begin
        rd_d = rd_q;
        pop  = 1'b0;
        if (clr) begin
            rd_d.phase = 1'b0;
            rd_d.bidx  = '0;
            rd_d.bcnt  = '0;
        end else if (consume && !empty) begin
            rd_d.bidx = rd_q.bidx + 1'b1;
            rd_d.bcnt = rd_q.bcnt + 1'b1;
            if (rd_q.bcnt == BCNT_W'(BYTE_W - 1)) begin
                rd_d.bcnt = '0;
                if (!rd_q.phase) begin
                    rd_d.phase = 1'b1;
                end else begin
                    pop        = 1'b1;
                    rd_d.phase = 1'b0;
                    rd_d.bidx  = '0;
                end
            end
        end else if (cs_rise && read_frame && !empty && rd_q.bcnt != '0) begin
            rd_d.bcnt = '0;
            if (!rd_q.phase) begin
                rd_d.phase = 1'b1;
            end else begin
                pop        = 1'b1;
                rd_d.phase = 1'b0;
                rd_d.bidx  = '0;
            end
        end

        if (cs_rise)                              rd_d.dout = 1'b0;
        else if (cs_fall || (sclk_fall && read_frame)) rd_d.dout = cur_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign dout = rd_q.dout;
endmodule

// File: rtl/rsp_cfg.sv
module rsp_cfg #(
    parameter int NREG  = 3,
    parameter int CFG_W = 8,
    localparam int ADDR_W = $clog2(NREG + 1),
    localparam int CNT_W  = $clog2(ADDR_W + CFG_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  bit_en,
    input  logic                  din,
    output logic [NREG*CFG_W-1:0] cfg_flat,
    output logic                  fifo_clr
);
    typedef struct packed {
        logic [NREG-1:0][CFG_W-1:0] regs;
        logic [ADDR_W-1:0]          addr;
        logic [CNT_W-1:0]           wcnt;
    } cfg_t;

    cfg_t cf_d, cf_q;
    int   slot;

    always_comb begin
        cf_d     = cf_q;
        fifo_clr = 1'b0;
        slot     = int'(cf_q.wcnt) - ADDR_W;
        if (start) begin
            cf_d.wcnt = '0;
            cf_d.addr = '0;
        end else if (bit_en) begin
            if (int'(cf_q.wcnt) < ADDR_W) begin
                cf_d.addr = (cf_q.addr << 1) | ADDR_W'(din);
            end else if (int'(cf_q.wcnt) < ADDR_W + CFG_W) begin
                if (int'(cf_q.addr) < NREG)
                    cf_d.regs[cf_q.addr][CFG_W-1-slot] = din;
                else if (int'(cf_q.addr) == NREG && slot == 0 && din)
                    fifo_clr = 1'b1;
            end
            if (cf_q.wcnt != CNT_W'(ADDR_W + CFG_W))
                cf_d.wcnt = cf_q.wcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cf_q <= '0;
        else        cf_q <= cf_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign cfg_flat[g*CFG_W +: CFG_W] = cf_q.regs[g];
    end
endmodule

// File: rtl/result_spi_port.sv
module result_spi_port
    import rsp_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 12,
    parameter int NREG   = 3,
    parameter int CFG_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  din,
    output logic                  dout,
    input  logic                  eoc_n,
    input  logic                  res_valid,
    input  logic [DATA_W-1:0]     res_data,
    output logic [NREG*CFG_W-1:0] cfg_regs,
    output logic                  corrupt
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        frame_e kind;
        logic   corrupt;
    } top_t;

    top_t top_d, top_q;

    logic              sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic              consume, wr_bit, push, pop, empty, fifo_clr, read_frame;
    logic [DATA_W-1:0] head;
    logic [LVL_W-1:0]  level;

    rsp_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise)
    );

    always_comb begin
        top_d = top_q;
        if (cs_rise)
            top_d.kind = FR_IDLE;
        else if (cs_fall)
            top_d.kind = FR_PEND;
        else if (sclk_rise && top_q.kind == FR_PEND)
            top_d.kind = din ? FR_WRITE : FR_READ;

        if (fifo_clr)              top_d.corrupt = 1'b0;
        else if (cs_fall && eoc_n) top_d.corrupt = 1'b1;

        consume    = sclk_rise && ((top_q.kind == FR_PEND && !din) || top_q.kind == FR_READ);
        wr_bit     = sclk_rise && (top_q.kind == FR_WRITE);
        read_frame = (top_q.kind == FR_READ);
        push       = res_valid && !top_q.corrupt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{kind: FR_IDLE, corrupt: 1'b0};
        else        top_q <= top_d;
    end

    assign corrupt = top_q.corrupt;

    rsp_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (res_data),
        .pop       (pop),
        .clr       (fifo_clr),
        .head      (head),
        .empty     (empty),
        .level     (level)
    );

    rsp_reader #(.DATA_W(DATA_W)) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .consume    (consume),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sclk_fall  (sclk_fall),
        .read_frame (read_frame),
        .clr        (fifo_clr),
        .head       (head),
        .empty      (empty),
        .pop        (pop),
        .dout       (dout)
    );

    rsp_cfg #(.NREG(NREG), .CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cs_fall),
        .bit_en   (wr_bit),
        .din      (din),
        .cfg_flat (cfg_regs),
        .fifo_clr (fifo_clr)
    );
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             dout,
    input logic             eoc_n,
    input logic             corrupt,
    input logic             sclk_fall,
    input logic             cs_fall,
    input logic             cs_rise,
    input logic             fifo_clr,
    input logic             pop,
    input logic             empty,
    input logic [CNT_W-1:0] level
);
    p_dout_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_fall && !cs_rise) |=> $stable(dout));

    p_dout_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !dout);

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

    p_corrupt_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && eoc_n) |=> corrupt);

    p_corrupt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (corrupt && !fifo_clr) |=> corrupt);

    p_no_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (corrupt && !fifo_clr && !pop) |=> (level == $past(level)));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (level == '0 && !corrupt));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));
endmodule

bind result_spi_port rsp_checker #(.DEPTH(DEPTH), .CNT_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .dout      (dout),
    .eoc_n     (eoc_n),
    .corrupt   (corrupt),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .fifo_clr  (fifo_clr),
    .pop       (pop),
    .empty     (empty),
    .level     (level)
);

// File: tb/result_spi_port_test.sv
module result_spi_port_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        dout;
    logic        eoc_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [23:0] cfg_regs;
    logic        corrupt;

    always #4 clk = ~clk;

    result_spi_port #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .eoc_n(eoc_n), .res_valid(res_valid), .res_data(res_data),
        .cfg_regs(cfg_regs), .corrupt(corrupt)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [11:0] mq[$];
    int          m_phase = 0, m_bidx = 0, m_bcnt = 0;
    logic        m_corrupt = 0;
    logic [7:0]  m_regs[3] = '{8'h00, 8'h00, 8'h00};
    logic [31:0] last_got;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit();
        logic [15:0] e;
        if (mq.size() == 0) return 1'b0;
        e = {4'b0, mq[0]};
        return e[15 - m_bidx];
    endfunction

    function automatic void m_advance_byte();
        m_bcnt = 0;
        if (m_phase == 0) m_phase = 1;
        else begin
            void'(mq.pop_front());
            m_phase = 0;
            m_bidx = 0;
        end
    endfunction

    function automatic void m_consume();
        if (mq.size() == 0) return;
        m_bidx++;
        m_bcnt++;
        if (m_bcnt == 8) m_advance_byte();
    endfunction

    task automatic do_push(input logic [11:0] d);
        @(negedge clk);
        res_valid = 1'b1;
        res_data  = d;
        @(negedge clk);
        res_valid = 1'b0;
        if (!m_corrupt && mq.size() < DEPTH) mq.push_back(d);
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs_n = 1'b0;
        if (eoc_n) m_corrupt = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_high(input bit rd);
        @(negedge clk);
        cs_n = 1'b1;
        if (rd && mq.size() != 0 && m_bcnt != 0) m_advance_byte();
        repeat (3) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic got);
        got  = dout;
        din  = b;
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_frame(input int n, input string req);
        logic [31:0] got, expv;
        logic        g, e;
        got  = '0;
        expv = '0;
        cs_low();
        for (int i = 0; i < n; i++) begin
            e = exp_bit();
            clock_bit(1'b0, g);
            got  = {got[30:0], g};
            expv = {expv[30:0], e};
            m_consume();
        end
        cs_high(1'b1);
        last_got = got;
        check(got == expv, req, got, expv);
    endtask

    task automatic write_frame(input int addr, input logic [7:0] data, input int nbits);
        logic g;
        cs_low();
        clock_bit(1'b1, g);
        clock_bit(addr[1], g);
        clock_bit(addr[0], g);
        for (int j = 0; j < nbits; j++) clock_bit(data[7-j], g);
        cs_high(1'b0);
        if (addr < 3) begin
            for (int j = 0; j < nbits; j++) m_regs[addr][7-j] = data[7-j];
        end else if (addr == 3 && nbits > 0 && data[7]) begin
            mq.delete();
            m_phase = 0;
            m_bidx = 0;
            m_bcnt = 0;
            m_corrupt = 1'b0;
        end
    endtask

    initial begin
        logic [11:0] a, b;
        logic [31:0] expv;
        void'($urandom(32'd1357));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        check(dout == 1'b0, "R2 reset dout", 32'(dout), 0);
        check(corrupt == 1'b0, "R8 reset corrupt", 32'(corrupt), 0);
        check(cfg_regs == 24'h0, "R6 reset cfg", 32'(cfg_regs), 0);

        read_frame(16, "R5 empty read");
        check(last_got == 32'h0, "R5 empty zeros", last_got, 0);
        do_push(12'hABC);
        read_frame(16, "R1 full entry");
        check(last_got == 32'h0ABC, "R1 word", last_got, 32'h0ABC);
        check(dout == 1'b0, "R2 idle dout", 32'(dout), 0);

        for (int k = 1; k <= 7; k++) begin
            a = 12'($urandom);
            b = 12'($urandom);
            do_push(a);
            do_push(b);
            read_frame(k, "R3 short first byte");
            read_frame(8, "R3 shifted byte");
            expv = 32'(({4'b0, a} >> (8 - k)) & 16'h00FF);
            check(last_got == expv, "R3 shifted value", last_got, expv);
            read_frame(16, "R4 next entry");
            check(last_got == 32'(b), "R4 next entry value", last_got, 32'(b));
        end

        for (int k = 1; k <= 7; k++) begin
            a = 12'($urandom);
            b = 12'($urandom);
            do_push(a);
            do_push(b);
            read_frame(8, "R1 first byte");
            read_frame(k, "R4 short second byte");
            read_frame(16, "R4 intact after");
            check(last_got == 32'(b), "R4 intact value", last_got, 32'(b));
        end

        write_frame(0, 8'h5A, 8);
        check(cfg_regs == {m_regs[2], m_regs[1], m_regs[0]}, "R6 full write", 32'(cfg_regs), 32'(24'h00005A));
        write_frame(1, 8'hFF, 8);
        write_frame(1, 8'h00, 3);
        check(cfg_regs[15:8] == 8'h1F, "R7 partial write", 32'(cfg_regs[15:8]), 32'h1F);
        write_frame(2, 8'hC3, 0);
        check(cfg_regs == {m_regs[2], m_regs[1], m_regs[0]}, "R7 zero-bit write", 32'(cfg_regs), 32'({m_regs[2], m_regs[1], m_regs[0]}));
        do_push(12'h3C5);
        write_frame(2, 8'h81, 8);
        read_frame(16, "R6 write frame consumes nothing");
        check(last_got == 32'h3C5, "R6 entry kept", last_got, 32'h3C5);

        for (int i = 0; i < DEPTH + 3; i++) do_push(12'(12'h100 + i));
        for (int i = 0; i < DEPTH; i++) read_frame(16, "R11 stored entries");
        check(last_got == 32'(12'h100 + DEPTH - 1), "R11 last kept", last_got, 32'(12'h100 + DEPTH - 1));
        read_frame(16, "R11 overflow dropped");
        check(last_got == 32'h0, "R11 nothing extra", last_got, 0);

        do_push(12'h777);
        do_push(12'h888);
        read_frame(4, "R3 partial before corrupt");
        eoc_n = 1'b1;
        cs_low();
        check(corrupt == 1'b1, "R8 set", 32'(corrupt), 1);
        cs_high(1'b1);
        eoc_n = 1'b0;
        do_push(12'h999);
        check(corrupt == 1'b1, "R8 sticky", 32'(corrupt), 1);
        write_frame(3, 8'h80, 1);
        check(corrupt == 1'b0, "R10 clears flag", 32'(corrupt), 0);
        read_frame(16, "R10 store emptied");
        check(last_got == 32'h0, "R9 R10 no entries", last_got, 0);
        do_push(12'h5E1);
        read_frame(16, "R10 position reset");
        check(last_got == 32'h5E1, "R10 fresh entry", last_got, 32'h5E1);

        for (int i = 0; i < 80; i++) begin
            case ($urandom % 4)
                0, 1: do_push(12'($urandom));
                2: read_frame(1 + int'($urandom % 24), "R3 R4 random read");
                default: begin
                    write_frame(int'($urandom % 3), 8'($urandom), int'($urandom % 9));
                    check(cfg_regs == {m_regs[2], m_regs[1], m_regs[0]}, "R7 random write",
                          32'(cfg_regs), 32'({m_regs[2], m_regs[1], m_regs[0]}));
                end
            endcase
        end
        while (mq.size() != 0) read_frame(16, "R1 drain");
        read_frame(16, "R5 final empty");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule